// File: doc/BRIEF.md
# Three-Wire Serial Memory Command Front End

This block is the slave side of a three-wire serial memory port. A host selects the block with a chip select, clocks bits in on a serial clock and data input, and reads results from a single data output that can be released to high impedance. Behind the port sits a register array of 64 words of 16 bits. There is also an 8-bit organisation with 128 words and one more address bit. The pins are sampled on the block's own system clock. Serial clock edges are found by comparing registered samples.

Each command is a start bit, a two-bit opcode and an address. The block can read a word, write one word or a page of up to eight words, erase one word, erase every word, or write one value to every word. Two special commands set and clear a write-enable latch. Programming does not begin until the host drops chip select. The array is updated at that point. A busy period of a set number of clock cycles then follows, and it stands in for the nonvolatile write time. While selected, the host can poll the data output to see whether the block is busy or ready.

Top module: `mw_eeprom_if`

## Requirements
- R1: After reset the data output is released (`do_oe` = 0), the write-enable latch is clear, and every word reads as all ones.
- R2: Bits with DI = 0 seen on rising SK while the block is selected and idle are ignored. A DI = 1 bit is the start bit. The next 2 bits are the opcode and the 6 bits after that are the address, MSB first. The opcodes are 10 read, 01 write, 11 erase and 00 special.
- R3: A read drives a single 0 on DO as soon as the last address bit is taken. On each following rising SK, DO presents the next bit of the addressed word, MSB first.
- R4: DO is released whenever CS is low. It is also released while a command is being shifted in.
- R5: Write, erase, erase-all and write-all have no effect unless write-enable has been set. Special command 00 with address bits [5:4] = 11 sets the latch, and 00 with [5:4] = 00 clears it.
- R6: During a write, each complete 16-bit word goes to the next address. The low 3 address bits wrap from 7 back to 0 inside the 8-word page, so a later word replaces an earlier word in the same slot.
- R7: A write is committed only when CS falls after at least one complete data word. Trailing bits that do not form a full word are dropped. A write with no complete word changes nothing and starts no busy period.
- R8: After a commit, DO is driven 0 while the block is selected. This lasts for WRITE_CYCLES clock cycles, and after that DO is driven 1.
- R9: The ready indication (DO = 1 while selected) stays across CS toggles until the next start bit. DO is released once that start bit is taken.
- R10: Erase (opcode 11) sets the addressed word to all ones and leaves the others alone. Special command 00 with [5:4] = 10 sets every word to all ones.
- R11: Special command 00 with [5:4] = 01 takes one data word and writes it to every address.
- R12: Commands sent while a busy period is running are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data input |
| do_o | output | 1 | Serial data output value |
| do_oe | output | 1 | Output enable for do_o; 0 means high impedance |

## Verification
The assertions check these rules on every cycle:
- the output is released within a cycle of chip select falling;
- an array update only happens with write-enable set and chip select low;
- the busy phase drives 0, runs its full count and exits only to ready;
- the ready phase drives 1;
- a read starts with the dummy 0.

Some behaviour shows only in the bench scenarios: the exact data order and address increment, page wrap overwriting, dropped partial words, ignored commands during busy, and the results of erase, erase-all and write-all. The bench checks these by reading the whole array back against a model it updates arithmetically.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_RDATA, S_WDATA, S_DONE, S_BUSY, S_READY
    } mw_state_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_PAGE, OP_ERASE, OP_ERAL, OP_WRAL
    } mw_op_e;
endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_s,
    output logic sk_rise,
    output logic di_s
);
    typedef struct packed {
        logic cs;
        logic sk;
        logic sk_prev;
        logic di;
    } pin_t;

    pin_t p_d, p_q;

    always_comb begin
        p_d         = p_q;
        p_d.cs      = cs;
        p_d.sk      = sk;
        p_d.sk_prev = p_q.sk;
        p_d.di      = di;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign cs_s    = p_q.cs;
    assign sk_rise = p_q.sk & ~p_q.sk_prev;
    assign di_s    = p_q.di;
endmodule

// File: rtl/mw_array.sv
module mw_array
    import mw_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 6,
    parameter int PAGE_W = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  mw_op_e                           op,
    input  logic [ADDR_W-1:0]                tgt_addr,
    input  logic [(1<<PAGE_W)-1:0][WORD_W-1:0] page_data,
    input  logic [(1<<PAGE_W)-1:0]           page_vld,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [WORD_W-1:0]                rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][WORD_W-1:0] words;

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam logic [ADDR_W-1:0] IA = ADDR_W'(i);
        logic [WORD_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            unique case (op)
                OP_ERAL:  word_d = '1;
                OP_WRAL:  word_d = page_data[0];
                OP_ERASE: if (tgt_addr == IA) word_d = '1;
                OP_PAGE:  if (tgt_addr[ADDR_W-1:PAGE_W] == IA[ADDR_W-1:PAGE_W]
                              && page_vld[IA[PAGE_W-1:0]])
                              word_d = page_data[IA[PAGE_W-1:0]];
                default:  word_d = word_q;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '1;
            else        word_q <= word_d;
        end

        assign words[i] = word_q;
    end

    assign rd_data = words[rd_addr];
endmodule

// File: rtl/mw_eeprom_if.sv
module mw_eeprom_if
    import mw_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int WRITE_CYCLES = 2000,
    parameter int PAGE_W       = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_o,
    output logic do_oe
);
    localparam int ADDR_W   = (WORD_W == 8) ? 7 : 6;
    localparam int CMD_BITS = 2 + ADDR_W;
    localparam int PAGE_N   = 1 << PAGE_W;
    localparam int CNT_W    = $clog2(WRITE_CYCLES + 1);
    localparam int BIT_W    = $clog2(WORD_W + 1);
    localparam int CCNT_W   = $clog2(CMD_BITS + 1);

    typedef struct packed {
        mw_state_e                      st;
        logic [CMD_BITS-1:0]            cmd;
        logic [CCNT_W-1:0]              ccnt;
        logic [ADDR_W-1:0]              ptr;
        logic [WORD_W-1:0]              sh;
        logic [BIT_W-1:0]               bcnt;
        logic [PAGE_N-1:0][WORD_W-1:0]  pbuf;
        logic [PAGE_N-1:0]              pvld;
        mw_op_e                         pend;
        logic                           wen;
        logic                           dout;
        logic [CNT_W-1:0]               wcnt;
    } regs_t;

    regs_t r_d, r_q;

    logic              cs_s, sk_rise, di_s;
    logic [WORD_W-1:0] rd_data;
    logic [CMD_BITS-1:0] full;
    logic [1:0]        opc, sub;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] word_in;
    logic              commit_ok;
    mw_op_e            op_c;

    mw_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s)
    );

    mw_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .op(op_c), .tgt_addr(r_q.ptr),
        .page_data(r_q.pbuf), .page_vld(r_q.pvld),
        .rd_addr(addr), .rd_data(rd_data)
    );

    assign full    = {r_q.cmd[CMD_BITS-2:0], di_s};
    assign opc     = full[CMD_BITS-1 -: 2];
    assign addr    = full[ADDR_W-1:0];
    assign sub     = addr[ADDR_W-1 -: 2];
    assign word_in = {r_q.sh[WORD_W-2:0], di_s};
    assign commit_ok = (r_q.pend == OP_ERASE) || (r_q.pend == OP_ERAL) ||
                       (((r_q.pend == OP_PAGE) || (r_q.pend == OP_WRAL)) && (|r_q.pvld));

    always_comb begin
        r_d  = r_q;
        op_c = OP_NONE;
        unique case (r_q.st)
            S_IDLE, S_READY: begin
                if (cs_s && sk_rise && di_s) begin
                    r_d.st   = S_CMD;
                    r_d.ccnt = '0;
                    r_d.pvld = '0;
                    r_d.pend = OP_NONE;
                end
            end
            S_CMD: begin
                if (!cs_s) begin
                    r_d.st = S_IDLE;
                end else if (sk_rise) begin
                    r_d.cmd  = full;
                    r_d.ccnt = r_q.ccnt + 1'b1;
                    if (r_q.ccnt == CCNT_W'(CMD_BITS - 1)) begin
                        r_d.st   = S_DONE;
                        r_d.bcnt = '0;
                        r_d.ptr  = addr;
                        unique case (opc)
                            2'b10: begin
                                r_d.st   = S_RDATA;
                                r_d.sh   = rd_data;
                                r_d.dout = 1'b0;
                            end
                            2'b01: if (r_q.wen) begin
                                r_d.st   = S_WDATA;
                                r_d.pend = OP_PAGE;
                            end
                            2'b11: if (r_q.wen) r_d.pend = OP_ERASE;
                            default: begin
                                unique case (sub)
                                    2'b11: r_d.wen = 1'b1;
                                    2'b00: r_d.wen = 1'b0;
                                    2'b10: if (r_q.wen) r_d.pend = OP_ERAL;
                                    default: if (r_q.wen) begin
                                        r_d.st   = S_WDATA;
                                        r_d.pend = OP_WRAL;
                                        r_d.ptr  = '0;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
            end
            S_RDATA: begin
                if (!cs_s) begin
                    r_d.st = S_IDLE;
                end else if (sk_rise) begin
                    if (r_q.bcnt == BIT_W'(WORD_W)) begin
                        r_d.st = S_DONE;
                    end else begin
                        r_d.dout = r_q.sh[WORD_W-1];
                        r_d.sh   = {r_q.sh[WORD_W-2:0], 1'b0};
                        r_d.bcnt = r_q.bcnt + 1'b1;
                    end
                end
            end
            S_WDATA, S_DONE: begin
                if (!cs_s) begin
                    if (commit_ok) begin
                        op_c     = r_q.pend;
                        r_d.st   = S_BUSY;
                        r_d.wcnt = CNT_W'(WRITE_CYCLES - 1);
                    end else begin
                        r_d.st = S_IDLE;
                    end
                end else if (sk_rise && r_q.st == S_WDATA) begin
                    r_d.sh = word_in;
                    if (r_q.bcnt == BIT_W'(WORD_W - 1)) begin
                        r_d.bcnt = '0;
                        r_d.pbuf[r_q.ptr[PAGE_W-1:0]] = word_in;
                        r_d.pvld[r_q.ptr[PAGE_W-1:0]] = 1'b1;
                        if (r_q.pend == OP_PAGE)
                            r_d.ptr[PAGE_W-1:0] = r_q.ptr[PAGE_W-1:0] + 1'b1;
                    end else begin
                        r_d.bcnt = r_q.bcnt + 1'b1;
                    end
                end
            end
            S_BUSY: begin
                if (r_q.wcnt == '0) r_d.st = S_READY;
                else                r_d.wcnt = r_q.wcnt - 1'b1;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.pend <= OP_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.st)
            S_BUSY:  do_o = 1'b0;
            S_READY: do_o = 1'b1;
            default: do_o = r_q.dout;
        endcase
        do_oe = cs_s && (r_q.st == S_RDATA || r_q.st == S_BUSY || r_q.st == S_READY);
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs,
    input logic      cs_s,
    input logic      do_o,
    input logic      do_oe,
    input mw_state_e st,
    input mw_op_e    op,
    input logic      wen,
    input logic      wcnt_zero
);
    p_hiz_deselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && !$past(cs)) |=> !do_oe);

    p_write_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_NONE) |-> wen);

    p_commit_cs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_NONE) |-> !cs_s);

    p_busy_drives_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BUSY && cs_s) |-> (do_oe && !do_o));

    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BUSY && !wcnt_zero) |=> (st == S_BUSY));

    p_ready_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_READY && cs_s) |-> (do_oe && do_o));

    p_read_dummy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RDATA && $past(st) != S_RDATA) |-> !do_o);

    p_busy_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BUSY) |=> (st == S_BUSY || st == S_READY));
endmodule

bind mw_eeprom_if mw_eeprom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .cs_s(cs_s),
    .do_o(do_o), .do_oe(do_oe), .st(r_q.st), .op(op_c),
    .wen(r_q.wen), .wcnt_zero(r_q.wcnt == '0)
);

// File: tb/tb_mw_eeprom_if.sv
`timescale 1ns/1ps
module tb_mw_eeprom_if;
    localparam int WC = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_o, do_oe;
    logic last_o, last_oe;
    int   vectors = 0, errors = 0;
    logic done = 1'b0;
    logic [15:0] expm [64];

    always #2.5 clk = ~clk;

    mw_eeprom_if #(.WORD_W(16), .WRITE_CYCLES(WC), .PAGE_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .do_o(do_o), .do_oe(do_oe)
    );

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic skb(input logic b);
        di = b;
        waitc(4);
        sk = 1'b1;
        waitc(4);
        last_o  = do_o;
        last_oe = do_oe;
        sk = 1'b0;
    endtask

    task automatic sel();
        cs = 1'b1;
        waitc(4);
    endtask

    task automatic desel();
        cs = 1'b0;
        waitc(4);
    endtask

    task automatic send_cmd(input logic [1:0] opc, input logic [5:0] a);
        skb(1'b1);
        for (int i = 1; i >= 0; i--) skb(opc[i]);
        for (int i = 5; i >= 0; i--) skb(a[i]);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) skb(w[i]);
    endtask

    function automatic logic [15:0] pat(input int a, input int salt);
        return 16'((a * 40503 + salt * 9973 + 4660) ^ (a << 9));
    endfunction

    task automatic read_chk(input int a, input int lead, input string tag);
        logic [15:0] w = '0;
        sel();
        for (int i = 0; i < lead; i++) skb(1'b0);
        send_cmd(2'b10, 6'(a));
        chk({tag, " dummy bit R3"}, {30'd0, last_oe, last_o}, 32'd2);
        for (int i = 0; i < 16; i++) begin
            skb(1'b0);
            w = {w[14:0], last_o};
        end
        desel();
        chk(tag, {16'd0, w}, {16'd0, expm[a]});
    endtask

    task automatic wait_ready(input int min_cnt);
        int n = 0;
        sel();
        chk("busy drives 0 R8", {30'd0, do_oe, do_o}, 32'd2);
        while (do_o !== 1'b1 && n < WC + 50) begin
            waitc(1);
            n++;
        end
        chk("ready drives 1 R8", {30'd0, do_oe, do_o}, 32'd3);
        chk("busy length R8", {31'd0, n >= min_cnt}, 32'd1);
        desel();
    endtask

    task automatic no_busy(input string tag);
        sel();
        chk(tag, {31'd0, do_oe}, 32'd0);
        desel();
    endtask

    task automatic special(input logic [1:0] s);
        sel();
        send_cmd(2'b00, {s, 4'b0000});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 64; a++) expm[a] = 16'hFFFF;
        waitc(10);
        rst_n = 1'b1;
        waitc(4);
        // R1: reset state
        chk("reset oe R1", {31'd0, do_oe}, 32'd0);
        read_chk(0, 0, "reset word R1");
        read_chk(63, 0, "reset word R1");

        // R5: write without enable ignored
        sel(); send_cmd(2'b01, 6'd5); send_word(16'h1234); desel();
        no_busy("disabled write no busy R5");
        read_chk(5, 0, "disabled write R5");

        // enable writes
        special(2'b11); desel();

        // R6: fill by full pages
        for (int p = 0; p < 8; p++) begin
            sel(); send_cmd(2'b01, 6'(p * 8));
            for (int k = 0; k < 8; k++) begin
                send_word(pat(p * 8 + k, 1));
                expm[p * 8 + k] = pat(p * 8 + k, 1);
            end
            desel();
            wait_ready(WC - 12);
        end
        for (int a = 0; a < 64; a++) read_chk(a, 0, "page fill R6");

        // R6: page wrap with overwrite, start at 13
        sel(); send_cmd(2'b01, 6'd13);
        for (int k = 0; k < 10; k++) begin
            send_word(pat(k, 2));
            expm[8 + ((5 + k) % 8)] = pat(k, 2);
        end
        desel();
        wait_ready(WC - 12);
        // R9: ready persists, released after start bit
        sel();
        chk("ready persists R9", {30'd0, do_oe, do_o}, 32'd3);
        skb(1'b1);
        chk("released after start R9", {31'd0, last_oe}, 32'd0);
        desel();
        for (int a = 8; a < 16; a++) read_chk(a, 0, "page wrap R6");

        // R2: leading zeros before start bit
        read_chk(13, 3, "leading zeros R2");
        read_chk(2, 1, "leading zeros R2");

        // R7: partial word discarded
        sel(); send_cmd(2'b01, 6'd40);
        for (int i = 0; i < 10; i++) skb(1'b0);
        desel();
        no_busy("partial word no busy R7");
        read_chk(40, 0, "partial word R7");

        // R4: released during command and after CS falls mid-read
        sel(); skb(1'b1);
        chk("oe during command R4", {31'd0, last_oe}, 32'd0);
        desel();
        sel(); send_cmd(2'b10, 6'd3);
        cs = 1'b0; waitc(4);
        chk("oe with cs low R4", {31'd0, do_oe}, 32'd0);

        // R10: erase single word
        sel(); send_cmd(2'b11, 6'd20); desel();
        expm[20] = 16'hFFFF;
        wait_ready(WC - 12);
        read_chk(20, 0, "erase word R10");
        read_chk(21, 0, "erase neighbour R10");

        // R12: command during busy ignored
        sel(); send_cmd(2'b11, 6'd30); desel();
        expm[30] = 16'hFFFF;
        sel(); send_cmd(2'b11, 6'd31); desel();
        wait_ready(0);
        read_chk(31, 0, "ignored while busy R12");
        read_chk(30, 0, "erase before busy R10");

        // R11: write-all
        special(2'b01); send_word(16'hA55A); desel();
        for (int a = 0; a < 64; a++) expm[a] = 16'hA55A;
        wait_ready(WC - 12);
        for (int a = 0; a < 64; a++) read_chk(a, 0, "write all R11");

        // R10: erase-all
        special(2'b10); desel();
        for (int a = 0; a < 64; a++) expm[a] = 16'hFFFF;
        wait_ready(WC - 12);
        read_chk(0, 0, "erase all R10");
        read_chk(37, 0, "erase all R10");
        read_chk(63, 0, "erase all R10");

        // R5: disable then write ignored
        special(2'b00); desel();
        sel(); send_cmd(2'b01, 6'd7); send_word(16'h1234); desel();
        no_busy("write after disable no busy R5");
        read_chk(7, 0, "write after disable R5");
        sel(); send_cmd(2'b11, 6'd8); desel();
        no_busy("erase after disable no busy R5");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule